// File: doc/BRIEF.md
# MDIO Management Master

This block performs single register accesses to an external PHY over the two-wire management interface. The host places a PHY address, a register number, a direction bit and a clock-range code on the command inputs. It pulses a command write with the go bit set. From then on the block runs one complete management frame on its own. The management clock is derived from the system clock by a divide ratio that the clock-range code selects. The data line is driven through an output value and an output enable, so a pad-level tristate can be placed outside the block.

A separate 16-bit data register holds the value to send on a write and receives the value returned by a read. The busy output is the host handshake. It rises one cycle after an accepted command and falls when the last bit period ends. The host polls it and then reads the data register.

Top module: `mdio_master`

## Requirements
- R1: After reset, busy, mdc and mdio_oe are 0 and data_q is 0x0000.
- R2: A command write with cmd_go set while idle raises busy at the next clock edge. A command write with cmd_go clear leaves the block idle.
- R3: The divide ratio follows cmd_range: code 3'b010 divides by 16, code 3'b011 divides by 26, and 3'b000 and every other code divide by 42. In each management clock period, mdc is high for DIV - DIV/2 system cycles. Busy stays high for exactly 64 * DIV system cycles.
- R4: A write frame, sampled at each mdc rising edge, is 32 ones, start 01, opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround 10 and the 16 data bits. Every field is sent MSB first, and mdio_oe is high for all 64 bits.
- R5: A read frame carries opcode 10. mdio_oe is high for the first 46 bits and low for the two turnaround bits and the 16 data bits.
- R6: On a read, mdio_in is sampled at the mdc rising edge of each of the 16 data bits, MSB first. The resulting word is in data_q when busy falls.
- R7: Whenever busy is low, mdc and mdio_oe are low.
- R8: Command writes made while busy is high are ignored. The running frame's fields and its length are unchanged.
- R9: Data register writes made while busy is high are ignored, and data_q does not change during a transaction except at its final edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_phy | input | 5 | PHY address for the transaction |
| cmd_reg | input | 5 | PHY register number |
| cmd_write | input | 1 | 1 selects a write, 0 selects a read |
| cmd_go | input | 1 | Go (busy) bit value written with the command |
| cmd_range | input | 3 | Clock-range code selecting the mdc divide ratio |
| data_wr | input | 1 | Data register write strobe |
| data_wdata | input | 16 | Value written to the data register |
| data_q | output | 16 | Data register contents |
| busy | output | 1 | Transaction in progress |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_in | input | 1 | Management data input from the pad |

## Verification
A wrong divider count appears at mdc within the first management clock period, as a high time or period that differs from the selected ratio. A slipped bit counter or frame shifter shows up at the first affected field, as a misplaced PHY or register bit in the captured frame. A late or early release of the data line shows up as the enable changing at a bit other than the 46th. A stale receive shifter or a missed completion only shows at the end of the frame, as a wrong data_q or a busy duration that is not exactly 64 periods.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam logic [1:0] START_PAT = 2'b01;
  localparam logic [1:0] OP_WR     = 2'b01;
  localparam logic [1:0] OP_RD     = 2'b10;
  localparam logic [1:0] TA_WR     = 2'b10;
  localparam logic [1:0] TA_RD     = 2'b11;
  localparam int         RANGE_W   = 3;

  typedef enum logic [RANGE_W-1:0] {
    RNG_SLOW = 3'b000,
    RNG_LOW  = 3'b010,
    RNG_MID  = 3'b011
  } range_code_e;

  function automatic int unsigned pick_div(input logic [RANGE_W-1:0] code,
                                           input int unsigned d_slow,
                                           input int unsigned d_low,
                                           input int unsigned d_mid);
    case (code)
      RNG_LOW: return d_low;
      RNG_MID: return d_mid;
      default: return d_slow;
    endcase
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] div_in,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] div_q, div_n;
  logic             mdc_q, mdc_n;
  logic [CNT_W-1:0] half_m1;

  assign half_m1  = (div_q >> 1) - CNT_W'(1);
  assign rise_evt = run && (cnt_q == half_m1);
  assign fall_evt = run && (cnt_q == div_q - CNT_W'(1));

  always_comb begin
    cnt_n = cnt_q;
    div_n = div_q;
    mdc_n = mdc_q;
    if (load) begin
      cnt_n = '0;
      div_n = div_in;
      mdc_n = 1'b0;
    end else if (run) begin
      if (fall_evt) begin
        cnt_n = '0;
        mdc_n = 1'b0;
      end else begin
        cnt_n = cnt_q + CNT_W'(1);
        if (rise_evt) mdc_n = 1'b1;
      end
    end else begin
      cnt_n = '0;
      mdc_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      mdc_q <= mdc_n;
      if (load) div_q <= div_n;
    end
  end

  assign mdc = mdc_q;

endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_pkg::*;
#(
  parameter int PHY_W   = 5,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr_sel,
  input  logic [PHY_W-1:0]  phy,
  input  logic [REG_W-1:0]  regn,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              mdio_in,
  output logic              run,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic              done,
  output logic              rd_flag,
  output logic [DATA_W-1:0] rx_data
);

  localparam int FRAME_W = PRE_LEN + 4 + PHY_W + REG_W + 2 + DATA_W;
  localparam int BIT_W   = $clog2(FRAME_W);
  localparam int REL_IDX = PRE_LEN + 4 + PHY_W + REG_W;
  localparam int DAT_IDX = REL_IDX + 2;

  logic               run_q, run_n;
  logic [BIT_W-1:0]   bit_q, bit_n;
  logic [FRAME_W-1:0] frame_q, frame_n, frame_load;
  logic [DATA_W-1:0]  rx_q, rx_n;
  logic               oe_q, oe_n;
  logic               wr_q, wr_n;
  logic               last_bit, in_data, keep_drive;

  assign frame_load = {{PRE_LEN{1'b1}}, START_PAT, (wr_sel ? OP_WR : OP_RD),
                       phy, regn, (wr_sel ? TA_WR : TA_RD), wdata};
  assign last_bit   = (bit_q == BIT_W'(FRAME_W - 1));
  assign in_data    = (bit_q >= BIT_W'(DAT_IDX));
  assign keep_drive = wr_q || (bit_q < BIT_W'(REL_IDX - 1));

  always_comb begin
    run_n   = run_q;
    bit_n   = bit_q;
    frame_n = frame_q;
    rx_n    = rx_q;
    oe_n    = oe_q;
    wr_n    = wr_q;
    if (start) begin
      run_n   = 1'b1;
      bit_n   = '0;
      frame_n = frame_load;
      rx_n    = '0;
      oe_n    = 1'b1;
      wr_n    = wr_sel;
    end else if (run_q) begin
      if (rise_evt && !wr_q && in_data)
        rx_n = {rx_q[DATA_W-2:0], mdio_in};
      if (fall_evt) begin
        if (last_bit) begin
          run_n = 1'b0;
          oe_n  = 1'b0;
        end else begin
          bit_n   = bit_q + BIT_W'(1);
          frame_n = {frame_q[FRAME_W-2:0], 1'b0};
          oe_n    = keep_drive;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      bit_q   <= '0;
      frame_q <= '0;
      rx_q    <= '0;
      oe_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      run_q <= run_n;
      oe_q  <= oe_n;
      if (start || run_q) begin
        bit_q   <= bit_n;
        frame_q <= frame_n;
        rx_q    <= rx_n;
      end
      if (start) wr_q <= wr_n;
    end
  end

  assign run      = run_q;
  assign mdio_out = run_q & frame_q[FRAME_W-1];
  assign mdio_oe  = oe_q;
  assign done     = run_q && fall_evt && last_bit;
  assign rd_flag  = !wr_q;
  assign rx_data  = rx_q;

endmodule

// File: rtl/mdio_hostregs.sv
module mdio_hostregs #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              cmd_go,
  input  logic              busy,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_wdata,
  input  logic              done,
  input  logic              rd_flag,
  input  logic [DATA_W-1:0] rx_data,
  output logic              accept,
  output logic [DATA_W-1:0] data_q
);

  logic [DATA_W-1:0] data_r, data_n;
  logic              data_en;

  assign accept = cmd_wr && cmd_go && !busy;

  always_comb begin
    data_en = 1'b0;
    data_n  = data_r;
    if (data_wr && !busy) begin
      data_en = 1'b1;
      data_n  = data_wdata;
    end else if (done && rd_flag) begin
      data_en = 1'b1;
      data_n  = rx_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_r <= '0;
    else if (data_en) data_r <= data_n;
  end

  assign data_q = data_r;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int PHY_W   = 5,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32,
  parameter int DIV_R0  = 42,
  parameter int DIV_R2  = 16,
  parameter int DIV_R3  = 26
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic [PHY_W-1:0]   cmd_phy,
  input  logic [REG_W-1:0]   cmd_reg,
  input  logic               cmd_write,
  input  logic               cmd_go,
  input  logic [RANGE_W-1:0] cmd_range,
  input  logic               data_wr,
  input  logic [DATA_W-1:0]  data_wdata,
  output logic [DATA_W-1:0]  data_q,
  output logic               busy,
  output logic               mdc,
  output logic               mdio_out,
  output logic               mdio_oe,
  input  logic               mdio_in
);

  localparam int DIV_MAX = int'(max3(DIV_R0, DIV_R2, DIV_R3));
  localparam int CNT_W   = $clog2(DIV_MAX + 1);

  logic              accept, run, done, rd_flag, rise_evt, fall_evt;
  logic [DATA_W-1:0] rx_data;
  logic [CNT_W-1:0]  div_sel;

  assign div_sel = CNT_W'(pick_div(cmd_range, DIV_R0, DIV_R2, DIV_R3));
  assign busy    = run;

  mdio_hostregs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_go(cmd_go), .busy(run),
    .data_wr(data_wr), .data_wdata(data_wdata), .done(done), .rd_flag(rd_flag),
    .rx_data(rx_data), .accept(accept), .data_q(data_q)
  );

  mdio_clkdiv #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .load(accept), .run(run), .div_in(div_sel),
    .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_engine #(.PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(accept), .wr_sel(cmd_write), .phy(cmd_phy),
    .regn(cmd_reg), .wdata(data_q), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .mdio_in(mdio_in), .run(run), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
    .done(done), .rd_flag(rd_flag), .rx_data(rx_data)
  );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_R0 = 42,
  parameter int DIV_R2 = 16,
  parameter int DIV_R3 = 26
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_wr,
  input logic               cmd_go,
  input logic               cmd_write,
  input logic [RANGE_W-1:0] cmd_range,
  input logic               busy,
  input logic               mdc,
  input logic               mdio_oe,
  input logic [DATA_W-1:0]  data_q
);

  localparam int DIV_MAX = int'(max3(DIV_R0, DIV_R2, DIV_R3));
  localparam int CNT_W   = $clog2(DIV_MAX + 1);

  logic [CNT_W-1:0] div_l, hi_cnt, exp_hi;
  logic             wr_l;
  logic             take;

  assign take   = cmd_wr && cmd_go && !busy;
  assign exp_hi = div_l - (div_l >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_l  <= '0;
      wr_l   <= 1'b0;
      hi_cnt <= '0;
    end else begin
      if (take) begin
        div_l <= CNT_W'(pick_div(cmd_range, DIV_R0, DIV_R2, DIV_R3));
        wr_l  <= cmd_write;
      end
      hi_cnt <= mdc ? hi_cnt + CNT_W'(1) : '0;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe)); // R7

  AST_CMD_START: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> busy); // R2

  AST_NO_SPURIOUS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !take) |=> !busy); // R2

  AST_MDC_HIGH_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc) |-> (hi_cnt == exp_hi)); // R3

  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_l) |-> mdio_oe); // R4

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(data_q))); // R9

endmodule

bind mdio_master mdio_master_chk #(
  .DATA_W(DATA_W), .DIV_R0(DIV_R0), .DIV_R2(DIV_R2), .DIV_R3(DIV_R3)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_go(cmd_go),
  .cmd_write(cmd_write), .cmd_range(cmd_range), .busy(busy), .mdc(mdc),
  .mdio_oe(mdio_oe), .data_q(data_q)
);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_wr, cmd_write, cmd_go, data_wr, mdio_in;
  logic [4:0]  cmd_phy, cmd_reg;
  logic [2:0]  cmd_range;
  logic [15:0] data_wdata, data_q;
  logic        busy, mdc, mdio_out, mdio_oe;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  mdio_master u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_phy(cmd_phy),
    .cmd_reg(cmd_reg), .cmd_write(cmd_write), .cmd_go(cmd_go),
    .cmd_range(cmd_range), .data_wr(data_wr), .data_wdata(data_wdata),
    .data_q(data_q), .busy(busy), .mdc(mdc), .mdio_out(mdio_out),
    .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  function automatic int div_of(input logic [2:0] code);
    if (code == 3'b010) return 16;
    if (code == 3'b011) return 26;
    return 42;
  endfunction

  task automatic set_data(input logic [15:0] v);
    @(negedge clk);
    data_wr = 1'b1;
    data_wdata = v;
    @(negedge clk);
    data_wr = 1'b0;
  endtask

  task automatic run_tx(input logic [2:0] code, input logic wr, input logic [4:0] phy,
                        input logic [4:0] rg, input logic [15:0] wval,
                        input logic [15:0] rval, input logic inject);
    int div, n, k, hi_run;
    logic prev_mdc, hi_bad;
    logic [63:0] expf, gotv, goev, exp_oe, mask;
    div = div_of(code);
    if (wr) set_data(wval);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_go = 1'b1; cmd_write = wr;
    cmd_phy = phy; cmd_reg = rg; cmd_range = code;
    @(negedge clk);
    cmd_wr = 1'b0;
    n = 0; k = 0; hi_run = 0; prev_mdc = 1'b0; hi_bad = 1'b0;
    gotv = '0; goev = '0; mdio_in = 1'b1;
    while (busy) begin
      n++;
      if (mdc && !prev_mdc && k < 64) begin
        gotv[63-k] = mdio_out;
        goev[63-k] = mdio_oe;
        k++;
      end
      if (mdc) hi_run++;
      else if (prev_mdc) begin
        if (hi_run != div - div/2) hi_bad = 1'b1;
        hi_run = 0;
        mdio_in = (k >= 48 && k < 64) ? rval[63-k] : 1'b1;
      end
      if (inject && n == 100) begin
        cmd_wr = 1'b1; cmd_go = 1'b1; cmd_write = ~wr;
        cmd_phy = ~phy; cmd_reg = ~rg; cmd_range = 3'b010;
        data_wr = 1'b1; data_wdata = ~wval ^ 16'h5A5A;
      end
      if (inject && n == 101) begin
        cmd_wr = 1'b0; data_wr = 1'b0;
      end
      prev_mdc = mdc;
      @(negedge clk);
    end
    cmd_wr = 1'b0; data_wr = 1'b0;
    expf = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg,
            (wr ? 2'b10 : 2'b00), (wr ? wval : 16'h0000)};
    exp_oe = wr ? 64'hFFFF_FFFF_FFFF_FFFF : 64'hFFFF_FFFF_FFFC_0000;
    mask = exp_oe;
    check(wr ? "R4 write frame bits" : "R5 read frame bits", gotv & mask, expf & mask);
    check(wr ? "R4 write output enable" : "R5 read release", goev, exp_oe);
    check("R3 busy length", 64'(n), 64'(64 * div));
    check("R3 mdc high time", 64'(hi_bad), 64'd0);
    check("R7 idle mdc/oe", {62'd0, mdc, mdio_oe}, 64'd0);
    if (!wr) check("R6 read data", 64'(data_q), 64'(rval));
    if (inject) begin
      check("R8 ignored command, frame count", 64'(k), 64'd64);
      if (wr) check("R9 data write ignored", 64'(data_q), 64'(wval));
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    cmd_wr = 1'b0; cmd_go = 1'b0; cmd_write = 1'b0; cmd_phy = '0; cmd_reg = '0;
    cmd_range = '0; data_wr = 1'b0; data_wdata = '0; mdio_in = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", {45'd0, busy, mdc, mdio_oe, data_q}, 64'd0);

    // R2: command write without go leaves the block idle
    cmd_wr = 1'b1; cmd_go = 1'b0; cmd_write = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 no start without go", {62'd0, busy, mdc}, 64'd0);

    // R2/R3: every clock-range code, write transactions
    for (int c = 0; c < 8; c++) begin
      run_tx(3'(c), 1'b1, 5'(c * 3 + 1), 5'(31 - c), 16'(16'hA5C3 ^ (c * 16'h1111)),
             16'h0, (c == 0));
    end

    // R4: sweep every PHY address
    for (int p = 0; p < 32; p++)
      run_tx(3'b010, 1'b1, 5'(p), 5'(p ^ 5'h15), 16'(p * 16'h0805 + 16'h8001), 16'h0, 1'b0);

    // R5/R6: sweep every register number with reads
    for (int r = 0; r < 32; r++)
      run_tx(3'b010, 1'b0, 5'(r ^ 5'h0A), 5'(r), 16'h0, 16'(r * 16'h9E37 + 16'h1234), 1'b0);

    // R6/R8/R9: reads at other ratios, with ignored writes mid-frame
    run_tx(3'b011, 1'b0, 5'h1F, 5'h00, 16'h0F0F, 16'hFFFF, 1'b1);
    run_tx(3'b010, 1'b0, 5'h00, 5'h1F, 16'h3C3C, 16'h8001, 1'b1);
    run_tx(3'b010, 1'b1, 5'h11, 5'h0E, 16'h0000, 16'h0, 1'b1);

    finish_run();
  end

endmodule